// File: doc/BRIEF.md
# Nibble Seed Mangle Engine

This block keeps sixteen 4-bit seed nibbles (indices 0 to 15) and scrambles them with the carry-steered nibble-chain mix used by a console lockout handshake. A one-cycle start request launches a mangle step. A step is a fixed number of rounds (three by default). Each round takes a fresh snapshot of entry 15 as its loop count and applies one mixing pass per clock, count+1 passes in all. When the last pass lands, the engine pulses done. Entry 0 is scratch: the mixer never touches it.

Between steps, a write port loads any nibble. A combinational read port exposes any nibble at all times, so the surrounding handshake logic can shift out bit 0 of each entry in index order and compare incoming bits. After reset the array holds the lock-side starting seed.

The controller is a four-state machine. IDLE moves to LOAD on start. LOAD latches the loop count from entry 15 and moves to PASS. PASS applies one pass per cycle and stays in PASS while the count is non-zero. At count zero, PASS goes back to LOAD if rounds remain, or to FIN on the last round. FIN raises done and returns to IDLE.

Top module: `nibble_mangle_engine`

## Requirements
- R1: After reset, busy and done are 0, and entries 1 to 15 read 0xB, 0x1, 0x4, 0xF, 0x4, 0xB, 0x5, 0x7, 0xF, 0xD, 0x6, 0x1, 0xE, 0x9, 0x8 in that index order.
- R2: rd_data always equals the entry addressed by rd_idx, with no clock delay. While idle, wr_en stores wr_data into the entry wr_idx (any of 0 to 15), and that value is readable from the next cycle.
- R3: While busy (including the cycle done is high), wr_en and start are ignored. The array changes only through passes, and no new step begins after the current one ends.
- R4: A start seen while idle raises busy on the following cycle. A write presented in the same cycle as that start is stored first, so the step uses the written value.
- R5: Each of the 3 rounds spends one cycle latching its count c from the current entry 15, then applies c+1 passes, one per cycle, with counts c, c-1, ..., 0. The start edge to the cycle done is seen therefore spans 1 + sum over rounds of (c+2) clock edges.
- R6: In every pass with count k, all sums are modulo 16. Entry 1 gains k+1. Entry 2 becomes the bitwise complement of (old entry 2 + new entry 1 + 1). Entry 3 becomes old entry 2 + old entry 3 + 1, and the pass takes the shifted branch exactly when that 5-bit sum exceeds 15.
- R7: In the normal branch: entry 4 gains old entry 3, then entry 5 gains new entry 4. With x = old entry 5 + 8, entry 6 becomes entry 6 + x when x < 16 and x - 16 otherwise. Entry 7 gains old entry 6 + 1. Each entry 8 to 15 gains (new value of the entry below) + 1.
- R8: In the shifted branch: entry 3 additionally gains old entry 3, then entry 4 gains new entry 3. The +8 rule uses old entry 4 and writes entry 5. Entry 6 gains old entry 5 + 1. Entries 7 to 15 ripple as in R7.
- R9: Entry 0 is never modified by a mangle step.
- R10: done is high for exactly one cycle, in the cycle right after the final pass is stored. busy is high from the cycle after the start until that done cycle inclusive, and low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to run one mangle step (taken only when idle) |
| wr_en | input | 1 | Nibble write enable (taken only when idle) |
| wr_idx | input | 4 | Index of the nibble to write |
| wr_data | input | 4 | Nibble value to write |
| rd_idx | input | 4 | Index of the nibble to read |
| rd_data | output | 4 | Current value of the addressed nibble |
| busy | output | 1 | A mangle step is in progress |
| done | output | 1 | One-cycle pulse when the step has finished |

## Verification
Two pairs of functions can collide in one cycle. The first pair is a write and the start of a step: the bench drives wr_en together with start, rewriting entry 15, and judges that the step latches the new count by comparing the run length and the final array against its model. The second pair is a write or start arriving while passes are being stored: the bench injects both mid-run, then checks that the scratch entry kept its old value, that the run length is unchanged, and that busy stays low after done. Both branch variants are driven by seed patterns chosen to force or avoid the entry-3 carry on the first pass, with every cycle's output compared to a queue of expected snapshots.

// File: rtl/mangle_pkg.sv
package mangle_pkg;

    localparam int NIB_W   = 4;
    localparam int NUM_NIB = 16;
    localparam int IDX_W   = $clog2(NUM_NIB);

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [NUM_NIB-1:0][NIB_W-1:0] seed_arr_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PASS,
        ST_FIN
    } eng_state_e;

    // Lock-side starting seed, entry 15 in the top nibble.
    localparam seed_arr_t DEFAULT_SEED = 64'h89E1_6DF7_5B4F_41B0;

    // Tail of one pass starting at accumulate index 'head':
    // head gains add0, head+1 gains new head, +8 rule on head+2,
    // head+3 gains old head+2 plus one, then a +1 ripple to the top.
    function automatic seed_arr_t chain_tail(input seed_arr_t a,
                                             input int        head,
                                             input nib_t      add0);
        seed_arr_t        r;
        logic [NIB_W:0]   x;
        r           = a;
        r[head]     = a[head] + add0;
        r[head + 1] = a[head + 1] + r[head];
        x           = {1'b0, a[head + 1]} + 5'd8;
        r[head + 2] = x[NIB_W] ? x[NIB_W-1:0] : (a[head + 2] + x[NIB_W-1:0]);
        r[head + 3] = a[head + 3] + a[head + 2] + nib_t'(1);
        for (int i = 1; i < NUM_NIB; i++) begin
            if (i >= head + 4) begin
                r[i] = a[i] + r[i - 1] + nib_t'(1);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/nibble_pass_alu.sv
module nibble_pass_alu
    import mangle_pkg::*;
(
    input  seed_arr_t cur,
    input  nib_t      cnt,
    output seed_arr_t nxt,
    output logic      shifted
);

    localparam int NUM_VAR  = 2;
    localparam int BASE_IDX = 4;

    seed_arr_t        pre;
    logic [NIB_W:0]   head_sum;
    seed_arr_t        tails [NUM_VAR];

    // Head of the pass: entries 1, 2 and 3 plus the branch carry.
    always_comb begin
        pre      = cur;
        pre[1]   = cur[1] + cnt + nib_t'(1);
        pre[2]   = ~(cur[2] + pre[1] + nib_t'(1));
        head_sum = {1'b0, cur[3]} + {1'b0, cur[2]} + 5'd1;
        pre[3]   = head_sum[NIB_W-1:0];
    end

    // Variant 0: normal chain from entry 4; variant 1: shifted chain from entry 3.
    for (genvar v = 0; v < NUM_VAR; v++) begin : g_tail
        assign tails[v] = chain_tail(pre, BASE_IDX - v, cur[3]);
    end

    assign shifted = head_sum[NIB_W];
    assign nxt     = shifted ? tails[1] : tails[0];

endmodule

// File: rtl/seed_store.sv
module seed_store
    import mangle_pkg::*;
#(
    parameter seed_arr_t INIT_SEED = DEFAULT_SEED
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ok,
    input  logic [IDX_W-1:0] wr_idx,
    input  nib_t             wr_data,
    input  logic             upd_en,
    input  seed_arr_t        upd_val,
    input  logic [IDX_W-1:0] rd_idx,
    output nib_t             rd_data,
    output seed_arr_t        arr_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_q <= INIT_SEED;
        end else if (upd_en) begin
            arr_q <= upd_val;
        end else if (wr_ok) begin
            arr_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = arr_q[rd_idx];

    // R3: writes are only let through when no pass is being stored
    assert_single_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_en && wr_ok))
        else $error("write and pass update in the same cycle");

    // R3: no pass and no accepted write leaves the array untouched
    assert_quiet_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !wr_ok) |=> $stable(arr_q))
        else $error("array changed without a source");

    // R9: a pass never alters the scratch entry
    assert_scratch_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (arr_q[0] == $past(arr_q[0])))
        else $error("scratch entry modified by a pass");

endmodule

// File: rtl/mangle_fsm.sv
module mangle_fsm
    import mangle_pkg::*;
#(
    parameter int ROUNDS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  nib_t top_nib,
    output nib_t cnt,
    output logic upd_en,
    output logic idle,
    output logic busy,
    output logic done
);

    localparam int              RND_W    = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
    localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);

    eng_state_e       state_q, state_d;
    nib_t             cnt_q;
    logic [RND_W-1:0] rnd_q;
    logic             cnt_zero;
    logic             last_rnd;

    assign cnt_zero = (cnt_q == '0);
    assign last_rnd = (rnd_q == LAST_RND);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LOAD;
            ST_LOAD: state_d = ST_PASS;
            ST_PASS: begin
                if (cnt_zero) begin
                    state_d = last_rnd ? ST_FIN : ST_LOAD;
                end
            end
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rnd_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) rnd_q <= '0;
                ST_LOAD: cnt_q <= top_nib;
                ST_PASS: begin
                    if (!cnt_zero) begin
                        cnt_q <= cnt_q - nib_t'(1);
                    end else if (!last_rnd) begin
                        rnd_q <= rnd_q + RND_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        idle   = (state_q == ST_IDLE);
        busy   = (state_q != ST_IDLE);
        upd_en = (state_q == ST_PASS);
        done   = (state_q == ST_FIN);
    end

    assign cnt = cnt_q;

    // R4: an accepted start makes the engine busy on the next cycle
    assert_start_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start) |=> busy)
        else $error("start not taken");

    // R10: done is a single-cycle pulse followed by idle
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy))
        else $error("done not a clean pulse");

    // R5: the round index never passes the last round
    assert_round_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_q <= LAST_RND)
        else $error("round index out of range");

    // R5: a zero count on the last round always ends the step
    assert_last_pass_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && cnt_zero && last_rnd) |=> done)
        else $error("step did not end after final pass");

endmodule

// File: rtl/nibble_mangle_engine.sv
module nibble_mangle_engine
    import mangle_pkg::*;
#(
    parameter int        ROUNDS    = 3,
    parameter seed_arr_t INIT_SEED = DEFAULT_SEED
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       wr_en,
    input  logic [3:0] wr_idx,
    input  logic [3:0] wr_data,
    input  logic [3:0] rd_idx,
    output logic [3:0] rd_data,
    output logic       busy,
    output logic       done
);

    seed_arr_t arr_q;
    seed_arr_t pass_val;
    nib_t      cnt;
    logic      upd_en;
    logic      idle;
    logic      wr_ok;
    logic      shifted;

    assign wr_ok = wr_en && idle;

    mangle_fsm #(
        .ROUNDS (ROUNDS)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .top_nib (arr_q[NUM_NIB-1]),
        .cnt     (cnt),
        .upd_en  (upd_en),
        .idle    (idle),
        .busy    (busy),
        .done    (done)
    );

    nibble_pass_alu u_alu (
        .cur     (arr_q),
        .cnt     (cnt),
        .nxt     (pass_val),
        .shifted (shifted)
    );

    seed_store #(
        .INIT_SEED (INIT_SEED)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ok   (wr_ok),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .upd_en  (upd_en),
        .upd_val (pass_val),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .arr_q   (arr_q)
    );

    // R6: the branch carry only matters while a pass is being stored
    assert_branch_known_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> !$isunknown(shifted))
        else $error("branch select unknown during pass");

endmodule

// File: tb/nibble_mangle_engine_bench.sv
module nibble_mangle_engine_bench;

    typedef logic [15:0][3:0] arr_t;
    localparam int NROUNDS = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_idx = '0;
    logic [3:0] wr_data = '0;
    logic [3:0] rd_idx;
    logic [3:0] rd_data;
    logic       busy;
    logic       done;

    logic       sweep = 1'b0;
    logic [3:0] sweep_idx = '0;
    logic [3:0] dir_idx = '0;
    assign rd_idx = sweep ? sweep_idx : dir_idx;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit cmp_en = 0;

    int seed_list [16] = '{0, 11, 1, 4, 15, 4, 11, 5, 7, 15, 13, 6, 1, 14, 9, 8};

    arr_t exp_arr;
    bit   exp_busy = 0;
    bit   exp_done = 0;
    arr_t q_arr [$];
    bit   q_done [$];
    int   exp_lat = 0;

    nibble_mangle_engine u_nibble_mangle_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .busy    (busy),
        .done    (done)
    );

    always #10 clk = ~clk;

    always @(negedge clk) sweep_idx <= sweep_idx + 4'd1;

    function automatic arr_t init_ref();
        arr_t a;
        for (int i = 0; i < 16; i++) a[i] = 4'(seed_list[i]);
        return a;
    endfunction

    function automatic logic [3:0] m16(int v);
        return 4'(v & 15);
    endfunction

    // One pass written straight from R6, R7 and R8.
    function automatic arr_t ref_pass(arr_t a, int k);
        arr_t r;
        int   t, x, h;
        r    = a;
        r[1] = m16(a[1] + k + 1);
        r[2] = m16(~(a[2] + r[1] + 1));
        t    = a[3] + a[2] + 1;
        r[3] = m16(t);
        if (t < 16) begin
            r[4] = m16(a[4] + a[3]);
            r[5] = m16(a[5] + r[4]);
            x    = a[5] + 8;
            r[6] = (x < 16) ? m16(a[6] + x) : m16(x);
            r[7] = m16(a[7] + a[6] + 1);
            h    = 8;
        end else begin
            r[3] = m16(t + a[3]);
            r[4] = m16(a[4] + r[3]);
            x    = a[4] + 8;
            r[5] = (x < 16) ? m16(a[5] + x) : m16(x);
            r[6] = m16(a[6] + a[5] + 1);
            h    = 7;
        end
        for (int i = h; i < 16; i++) r[i] = m16(a[i] + r[i-1] + 1);
        return r;
    endfunction

    // Expected snapshot after each clock edge of a step, from R5 and R10.
    task automatic build_queue(input arr_t a0);
        arr_t a;
        int   c;
        a = a0;
        q_arr.delete();
        q_done.delete();
        q_arr.push_back(a); q_done.push_back(1'b0);
        for (int r = 0; r < NROUNDS; r++) begin
            c = a[15];
            q_arr.push_back(a); q_done.push_back(1'b0);
            for (int k = c; k >= 0; k--) begin
                a = ref_pass(a, k);
                q_arr.push_back(a);
                q_done.push_back((r == NROUNDS - 1) && (k == 0));
            end
        end
        exp_lat = q_arr.size();
    endtask

    initial exp_arr = init_ref();

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_arr  = init_ref();
            exp_busy = 0;
            exp_done = 0;
            q_arr.delete();
            q_done.delete();
        end else if (exp_busy) begin
            if (q_arr.size() > 0) begin
                exp_arr  = q_arr.pop_front();
                exp_done = q_done.pop_front();
            end else begin
                exp_busy = 0;
                exp_done = 0;
            end
        end else begin
            if (wr_en) exp_arr[wr_idx] = wr_data;
            if (start) begin
                build_queue(exp_arr);
                exp_arr  = q_arr.pop_front();
                exp_done = q_done.pop_front();
                exp_busy = 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Every-cycle comparison against the model.
    always @(posedge clk) begin
        #5;
        if (cmp_en) begin
            chk(busy === exp_busy, "R10 busy", int'(busy), int'(exp_busy));
            chk(done === exp_done, "R10 done", int'(done), int'(exp_done));
            chk(rd_data === exp_arr[rd_idx], "R6 R7 R8 nibble", int'(rd_data), int'(exp_arr[rd_idx]));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL R5 watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic write_nib(input int idx, input int val);
        @(negedge clk);
        wr_en = 1; wr_idx = 4'(idx); wr_data = 4'(val);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic read_chk(input int idx, input int expv, input string req);
        dir_idx = 4'(idx);
        #1;
        chk(rd_data === 4'(expv), req, int'(rd_data), expv);
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 16; i++) read_chk(i, int'(exp_arr[i]), req);
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 1;
        while (!done && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk(n == exp_lat, req, n, exp_lat);
        @(negedge clk);
        chk(!busy && !done, "R10 idle after done", int'(busy) + 2 * int'(done), 0);
    endtask

    task automatic run_step(input bit with_wr, input int idx, input int val, input string req);
        @(negedge clk);
        start = 1;
        if (with_wr) begin
            wr_en = 1; wr_idx = 4'(idx); wr_data = 4'(val);
        end
        @(negedge clk);
        start = 0; wr_en = 0;
        chk(busy === 1'b1, "R4 busy after start", int'(busy), 1);
        wait_done(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_en = 1;

        // R1: reset contents and flags
        chk(busy === 1'b0 && done === 1'b0, "R1 flags", int'(busy) + 2 * int'(done), 0);
        for (int i = 1; i < 16; i++) read_chk(i, seed_list[i], "R1");

        // R5: default seed, three rounds
        sweep = 1;
        run_step(0, 0, 0, "R5 latency default");
        sweep = 0;
        check_all("R6 default result");

        // R2: write and read back
        write_nib(5, 12);
        read_chk(5, 12, "R2");
        write_nib(0, 10);
        read_chk(0, 10, "R2");

        // R7: no carry on the first pass
        for (int i = 1; i < 16; i++) write_nib(i, 0);
        write_nib(15, 1);
        sweep = 1;
        run_step(0, 0, 0, "R5 latency normal pattern");
        sweep = 0;
        check_all("R7");

        // R8: carry on the first pass
        for (int i = 1; i < 16; i++) write_nib(i, 0);
        write_nib(2, 15);
        write_nib(3, 15);
        sweep = 1;
        run_step(0, 0, 0, "R5 latency shifted pattern");
        sweep = 0;
        check_all("R8");

        // R4: write to entry 15 in the start cycle
        sweep = 1;
        run_step(1, 15, 3, "R4 latency uses written count");
        sweep = 0;
        check_all("R4 result");

        // R3: writes and start while busy are dropped
        sweep = 1;
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        repeat (3) @(negedge clk);
        wr_en = 1; wr_idx = 4'd0; wr_data = 4'd5; start = 1;
        @(negedge clk);
        wr_en = 0; start = 0;
        while (!done) @(negedge clk);
        wr_en = 1; wr_idx = 4'd0; wr_data = 4'd6; start = 1;
        @(negedge clk);
        wr_en = 0; start = 0;
        chk(busy === 1'b0, "R3 no restart after done", int'(busy), 0);
        @(negedge clk);
        chk(busy === 1'b0, "R3 still idle", int'(busy), 0);
        sweep = 0;
        read_chk(0, 10, "R3 busy write dropped");
        read_chk(0, 10, "R9 scratch kept");
        check_all("R3 array");

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule